// File: doc/BRIEF.md
# Frame-Selectable Down Sampler

This block lowers the sample rate of a data stream by an integer factor on a single fast clock. Two enables set the timing. `fast_en` marks each cycle in which `din` carries a valid input sample. `slow_en` marks the output-rate instant and closes a frame. A frame is the set of input samples accepted since the previous `slow_en`, up to and including the cycle in which `slow_en` is high. From each frame exactly one sample is kept and all the others are discarded. The decimation factor M is therefore set by how often the surrounding enable generator pulses `slow_en`: once every M pulses of `fast_en`.

Two parameters choose the form.

- `LATENCY` set to 1 or more gives a registered output. `KEEP_FIRST` then selects the sample that is kept:
  - With `KEEP_FIRST` = 0 the last sample of the frame is kept. This costs only the output register.
  - With `KEEP_FIRST` = 1 the first sample is kept. This costs one more capture register and a frame-open flag.
  - Latencies above 1 add plain delay stages after the output register.
- `LATENCY` = 0 gives a shutter. The current input passes through an output multiplexer in the cycle of the first sample of each frame. The multiplexer select comes from a registered frame-open flag. This form has a combinational path from `din` to `dout`, and the surrounding timing must allow for it.

Top module: `frame_downsampler`

## Requirements
- R1: `slow_en` is only asserted together with `fast_en`. A frame is the `fast_en` cycles after the previous `slow_en` (or after reset) through the `slow_en` cycle. Exactly one sample of each frame reaches `dout`.
- R2: With `LATENCY` = 1 and `KEEP_FIRST` = 0, `dout` equals the `din` sampled in the `slow_en` cycle, from the following cycle on.
- R3: With `LATENCY` = 1 and `KEEP_FIRST` = 1, `dout` equals the first sample of the frame, from the cycle after `slow_en`. A frame of one sample yields that sample.
- R4: With `LATENCY` = 0, in the cycle of the first `fast_en` of a frame, `dout` equals `din` in that same cycle, with no register between them.
- R5: With `LATENCY` = N > 1, `dout` shows the value the `LATENCY` = 1 form would show N-1 cycles later. The kept sample is chosen by `KEEP_FIRST` as in R2 and R3.
- R6: Between updates `dout` holds its value. Samples other than the kept one have no effect on `dout`.
- R7: During and right after reset, `dout` and every internal register are zero. The first `fast_en` after reset opens a new frame.
- R8: In cycles where `fast_en` is low, `din` is not a sample. It neither counts toward a frame nor reaches `dout`, however many such cycles separate samples.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| fast_en | input | 1 | Input-rate enable: `din` holds a sample |
| slow_en | input | 1 | Output-rate enable: closes the current frame |
| din | input | DATA_W | Input sample |
| dout | output | DATA_W | Decimated output sample |

## Verification
The two functions that can fall in the same cycle are closing a frame and opening a new one. Frames of length one make `slow_en` coincide with the first `fast_en` of the frame. In that cycle the keep-first and shutter forms must both capture and release the same sample, and the frame flag must end up closed. The bench provokes this with one-sample frames mixed between long frames and frames spread by idle gaps. On every clock it compares four instances, one for each form, against a behavioural model. The model keeps each frame as a queue and derives the expected output from the queue's head or tail.

// File: rtl/ds_pkg.sv
package ds_pkg;

    typedef enum logic [1:0] {
        DS_SHUTTER    = 2'd0,
        DS_HOLD_LAST  = 2'd1,
        DS_HOLD_FIRST = 2'd2
    } ds_variant_e;

    function automatic ds_variant_e ds_pick(input int latency, input int keep_first);
        if (latency == 0)
            return DS_SHUTTER;
        else if (keep_first != 0)
            return DS_HOLD_FIRST;
        else
            return DS_HOLD_LAST;
    endfunction

endpackage

// File: rtl/ds_frame_track.sv
module ds_frame_track (
    input  logic clk,
    input  logic rst_n,
    input  logic fast_en,
    input  logic slow_en,
    output logic frame_open
);

    typedef struct packed {
        logic open;
    } trk_t;

    trk_t trk_d, trk_q;

    always_comb begin
        trk_d = trk_q;
        if (slow_en)
            trk_d.open = 1'b0;
        else if (fast_en)
            trk_d.open = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            trk_q <= '0;
        else
            trk_q <= trk_d;
    end

    assign frame_open = trk_q.open;

    AST_SLOW_NEEDS_FAST: assert property (@(posedge clk) disable iff (!rst_n)
        slow_en |-> fast_en); // R1
    AST_CLOSE_ON_SLOW: assert property (@(posedge clk) disable iff (!rst_n)
        slow_en |=> !frame_open); // R1
    AST_OPEN_ON_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
        (fast_en && !slow_en) |=> frame_open); // R1

endmodule

// File: rtl/ds_first_capture.sv
module ds_first_capture #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fast_en,
    input  logic              frame_open,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] kept
);

    typedef struct packed {
        logic [DATA_W-1:0] first;
    } cap_t;

    cap_t cap_d, cap_q;
    logic opening;

    assign opening = fast_en & ~frame_open;

    always_comb begin
        cap_d = cap_q;
        if (opening)
            cap_d.first = din;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cap_q <= '0;
        else
            cap_q <= cap_d;
    end

    assign kept = opening ? din : cap_q.first;

    AST_FIRST_LOADED: assert property (@(posedge clk) disable iff (!rst_n)
        (fast_en && !frame_open) |=> cap_q.first == $past(din)); // R3
    AST_FIRST_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        frame_open |=> $stable(cap_q.first)); // R3

endmodule

// File: rtl/ds_out_stage.sv
module ds_out_stage #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] d,
    output logic [DATA_W-1:0] q
);

    typedef struct packed {
        logic [DEPTH-1:0][DATA_W-1:0] pipe;
    } stg_t;

    stg_t stg_d, stg_q;

    always_comb begin
        stg_d = stg_q;
        if (load)
            stg_d.pipe[0] = d;
        for (int k = 1; k < DEPTH; k++)
            stg_d.pipe[k] = stg_q.pipe[k-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            stg_q <= '0;
        else
            stg_q <= stg_d;
    end

    assign q = stg_q.pipe[DEPTH-1];

    AST_LOAD_TAKES_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> stg_q.pipe[0] == $past(d)); // R2
    AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(stg_q.pipe[0])); // R6

endmodule

// File: rtl/ds_zero_shutter.sv
module ds_zero_shutter #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fast_en,
    input  logic              frame_open,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout
);

    typedef struct packed {
        logic [DATA_W-1:0] hold;
    } sh_t;

    sh_t sh_d, sh_q;
    logic pass;

    assign pass = fast_en & ~frame_open;
    assign dout = pass ? din : sh_q.hold;

    always_comb begin
        sh_d = sh_q;
        sh_d.hold = dout;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            sh_q <= '0;
        else
            sh_q <= sh_d;
    end

    AST_SHUT_INSIDE_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        frame_open |-> $stable(dout)); // R6

endmodule

// File: rtl/frame_downsampler.sv
module frame_downsampler #(
    parameter int DATA_W     = 8,
    parameter int LATENCY    = 1,
    parameter int KEEP_FIRST = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fast_en,
    input  logic              slow_en,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout
);

    import ds_pkg::*;

    localparam ds_variant_e VARIANT = ds_pick(LATENCY, KEEP_FIRST);
    localparam int          DEPTH   = (LATENCY < 1) ? 1 : LATENCY;

    generate
        if (VARIANT == DS_SHUTTER) begin : g_shutter
            logic frame_open;
            ds_frame_track u_track (
                .clk(clk), .rst_n(rst_n), .fast_en(fast_en),
                .slow_en(slow_en), .frame_open(frame_open));
            ds_zero_shutter #(.DATA_W(DATA_W)) u_shutter (
                .clk(clk), .rst_n(rst_n), .fast_en(fast_en),
                .frame_open(frame_open), .din(din), .dout(dout));
        end else if (VARIANT == DS_HOLD_FIRST) begin : g_first
            logic              frame_open;
            logic [DATA_W-1:0] kept;
            ds_frame_track u_track (
                .clk(clk), .rst_n(rst_n), .fast_en(fast_en),
                .slow_en(slow_en), .frame_open(frame_open));
            ds_first_capture #(.DATA_W(DATA_W)) u_capture (
                .clk(clk), .rst_n(rst_n), .fast_en(fast_en),
                .frame_open(frame_open), .din(din), .kept(kept));
            ds_out_stage #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_out (
                .clk(clk), .rst_n(rst_n), .load(slow_en), .d(kept), .q(dout));
        end else begin : g_last
            ds_out_stage #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_out (
                .clk(clk), .rst_n(rst_n), .load(slow_en), .d(din), .q(dout));
        end
    endgenerate

endmodule

// File: tb/frame_downsampler_tb.sv
module frame_downsampler_tb;

    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         fast_en = 1'b0;
    logic         slow_en = 1'b0;
    logic [W-1:0] din = '0;
    logic [W-1:0] dout0, dout1, dout2, dout3;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #10 clk = ~clk;

    // c0: last, latency 1   (R2)
    // c1: first, latency 1  (R3)
    // c2: shutter, latency 0 (R4)
    // c3: first, latency 3  (R5)
    frame_downsampler #(.DATA_W(W), .LATENCY(1), .KEEP_FIRST(0)) u_dut (
        .clk(clk), .rst_n(rst_n), .fast_en(fast_en), .slow_en(slow_en), .din(din), .dout(dout0));
    frame_downsampler #(.DATA_W(W), .LATENCY(1), .KEEP_FIRST(1)) u_dut_first (
        .clk(clk), .rst_n(rst_n), .fast_en(fast_en), .slow_en(slow_en), .din(din), .dout(dout1));
    frame_downsampler #(.DATA_W(W), .LATENCY(0), .KEEP_FIRST(0)) u_dut_zero (
        .clk(clk), .rst_n(rst_n), .fast_en(fast_en), .slow_en(slow_en), .din(din), .dout(dout2));
    frame_downsampler #(.DATA_W(W), .LATENCY(3), .KEEP_FIRST(1)) u_dut_deep (
        .clk(clk), .rst_n(rst_n), .fast_en(fast_en), .slow_en(slow_en), .din(din), .dout(dout3));

    // Behavioural model: the open frame is a queue of samples
    int frame_q[$];
    int regv[4];
    int pipe[4][8];
    int held;
    int lat_of[4]   = '{1, 1, 0, 3};
    bit first_of[4] = '{1'b0, 1'b1, 1'b0, 1'b1};
    string phase    = "R7";

    always @(posedge clk) begin
        if (!rst_n) begin
            frame_q.delete();
            held = 0;
            for (int c = 0; c < 4; c++) begin
                regv[c] = 0;
                for (int k = 0; k < 8; k++) pipe[c][k] = 0;
            end
        end else begin
            if (fast_en && frame_q.size() == 0) held = int'(din);
            if (fast_en) frame_q.push_back(int'(din));
            if (slow_en) begin
                for (int c = 0; c < 4; c++)
                    regv[c] = first_of[c] ? frame_q[0] : frame_q[frame_q.size()-1];
                frame_q.delete();
            end
            for (int c = 0; c < 4; c++) begin
                for (int k = 7; k > 0; k--) pipe[c][k] = pipe[c][k-1];
                pipe[c][0] = regv[c];
            end
        end
    end

    function automatic int expect_of(int c);
        if (!rst_n) return 0;
        if (lat_of[c] == 0)
            return (fast_en && frame_q.size() == 0) ? int'(din) : held;
        return pipe[c][lat_of[c]-1];
    endfunction

    task automatic check_one(int c, logic [W-1:0] got);
        string tag;
        int exp;
        case (c)
            0: tag = "R2";
            1: tag = "R3";
            2: tag = "R4";
            default: tag = "R5";
        endcase
        exp = expect_of(c);
        n_tests++;
        if (int'(got) != exp) begin
            n_fail++;
            $display("FAIL %s %s cfg%0d: got %0h expected %0h at %0t", phase, tag, c, got, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (!done) begin
            check_one(0, dout0);
            check_one(1, dout1);
            check_one(2, dout2);
            check_one(3, dout3);
        end
    end

    task automatic step(bit fe, bit se, logic [W-1:0] d);
        @(posedge clk);
        #2;
        fast_en = fe;
        slow_en = se;
        din     = d;
    endtask

    task automatic frame(int len, int gap);
        for (int i = 0; i < len; i++) begin
            for (int g = 0; g < gap; g++)
                step(1'b0, 1'b0, W'($urandom_range(0, 255)));
            step(1'b1, (i == len - 1), W'($urandom_range(0, 255)));
        end
    endtask

    task automatic do_reset();
        @(posedge clk);
        #2;
        phase   = "R7";
        rst_n   = 1'b0;
        fast_en = 1'b0;
        slow_en = 1'b0;
        din     = 8'hA5;
        repeat (3) @(posedge clk);
        #2;
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #2;
        rst_n = 1'b1;
        // R1: regular frames of four, one sample per cycle
        phase = "R1";
        for (int f = 0; f < 20; f++) frame(4, 0);
        // R8: samples separated by idle cycles carrying junk data
        phase = "R8";
        for (int f = 0; f < 15; f++) frame(3, 1 + (f % 3));
        // R6: mixed lengths including one-sample frames
        phase = "R6";
        for (int f = 0; f < 40; f++) frame(1 + (f % 5 == 0 ? 0 : f % 4), f % 2);
        for (int f = 0; f < 10; f++) frame(1, 0);
        // R7: reset in the middle of a frame, then resume
        frame(2, 0);
        step(1'b1, 1'b0, 8'h3C);
        do_reset();
        phase = "R1";
        for (int f = 0; f < 10; f++) frame(2 + (f % 3), f % 2);
        step(1'b0, 1'b0, 8'h00);
        repeat (6) step(1'b0, 1'b0, W'($urandom_range(0, 255)));
        @(negedge clk);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            done = 1'b1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule